// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block is a management register file that answers like a small, always-cooperative Ethernet transceiver. It holds thirty-two 16-bit registers selected by a 5-bit register number. A write strobe stores data on the clock edge, and the read data follows the selected register combinationally. Most entries simply return what was last written to them. Three entries are computed instead: the basic status word, the link partner ability word and a vendor-style diagnostic word. They are derived from the local advertisement register and a link-up input, so autonegotiation always appears to finish with the best modes that are advertised.

A MAC-side controller or a management bus decoder sits in front of the block and drives the register number, write data and strobe. The diagnostic duplex result is also brought out as a separate pin. This lets a MAC compare it with its own duplex setting without issuing a read. The reset is asserted asynchronously and released through a synchronizer inside the block.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While reset is held, and after it, the read data is 0x3100 for register 0, 0x0300 for register 2, 0xE400 for register 3, 0x01E1 for register 4 (advertisement) and 0x0000 for every other stored register.
- R2: A write with the strobe high stores the data on the rising clock edge. From then on, reading that register number returns the data, for every register except 1, 5 and 18. A write to one register leaves the others unchanged.
- R3: With the link state up, register 1 reads 0x782C. This sets bits 14, 13, 12 and 11 (speed and duplex abilities), bit 5 (negotiation complete), bit 3 (negotiation capable) and bit 2 (link).
- R4: With the link state down, register 1 reads 0x0000.
- R5: Register 5 reads 0x4001 OR (register 4 AND 0x01E0), whatever the link state.
- R6: With the link up, register 18 bit 10 (100 Mb/s) is set when register 4 bit 7 (100 half, 0x0080) or bit 8 (100 full, 0x0100) is set. All bits other than 10 and 11 read 0.
- R7: With the link up, register 18 bit 11 (full duplex) is set when register 4 bit 8 (100 full) or bit 6 (10 full, 0x0040) is set. Register 4 bit 5 (10 half, 0x0020) sets neither bit. The full_duplex_o output always equals register 18 bit 11.
- R8: With the link down, register 18 reads 0x0000 and full_duplex_o is 0.
- R9: Writes to registers 1, 5 and 18 are accepted but do not change what those registers read.
- R10: The link state is link_up_i sampled on each rising clock edge. It is up while reset is held, whatever the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_up_i | input | 1 | Line link indication, 1 = up |
| reg_sel_i | input | 5 | Register number for both read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Combinational read data of the selected register |
| full_duplex_o | output | 1 | Diagnostic full-duplex result |

## Verification
The hardest case to reach from the ports is a reading of the computed registers that follows a write to that same register number. The stored value is never visible there, so the stimulus writes all-ones or zeros into registers 1, 5 and 18 and reads each one back at once. Each read must still show the value computed from the advertisement. The link-up value during reset is checked by holding link_up_i low through reset and reading register 1 before the synchronized reset releases. A walk over every advertisement mode, with the link both up and down, covers the duplex and speed decoding.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int MGMT_DATA_W = 16;

  // register numbers whose behaviour is decoded
  localparam int IDX_CTRL    = 0;
  localparam int IDX_STATUS  = 1;
  localparam int IDX_ID_HI   = 2;
  localparam int IDX_ID_LO   = 3;
  localparam int IDX_ADV     = 4;
  localparam int IDX_PARTNER = 5;
  localparam int IDX_DIAG    = 18;

  // advertisement bit positions
  localparam int ADV_10_HALF  = 5;
  localparam int ADV_10_FULL  = 6;
  localparam int ADV_100_HALF = 7;
  localparam int ADV_100_FULL = 8;

  // diagnostic word bit positions
  localparam int DIAG_SPEED_BIT  = 10;
  localparam int DIAG_DUPLEX_BIT = 11;

  localparam logic [15:0] STATUS_LINK_UP = 16'h782C;
  localparam logic [15:0] PARTNER_FIXED  = 16'h4001;
  localparam logic [15:0] ADV_MODE_MASK  = 16'h01E0;

  function automatic logic [15:0] reg_reset_value(int idx);
    case (idx)
      IDX_CTRL:  reg_reset_value = 16'h3100;
      IDX_ID_HI: reg_reset_value = 16'h0300;
      IDX_ID_LO: reg_reset_value = 16'hE400;
      IDX_ADV:   reg_reset_value = 16'h01E1;
      default:   reg_reset_value = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
#(
  parameter  int NUM_REGS = 32,
  parameter  int DATA_W   = MGMT_DATA_W,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                sel_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic                             link_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o,
  output logic                             link_o
);

  // one storage word per register number
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    assign hit = wr_en_i && (sel_i == ADDR_W'(g));

    always_comb begin
      word_d = word_q;
      if (hit) begin
        word_d = wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= DATA_W'(reg_reset_value(g));
      end else begin
        word_q <= word_d;
      end
    end

    assign regs_o[g] = word_q;
  end

  // sampled link state, up out of reset
  logic link_d;
  logic link_q;

  always_comb begin
    link_d = link_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b1;
    end else begin
      link_q <= link_d;
    end
  end

  assign link_o = link_q;

endmodule

// File: rtl/phy_status_synth.sv
module phy_status_synth
  import phy_mgmt_pkg::*;
(
  input  logic        link_i,
  input  logic [15:0] adv_i,
  output logic [15:0] status_o,
  output logic [15:0] partner_o,
  output logic [15:0] diag_o,
  output logic        duplex_o
);

  logic speed_100;
  logic full_dup;

  always_comb begin
    speed_100 = adv_i[ADV_100_HALF] | adv_i[ADV_100_FULL];
    full_dup  = adv_i[ADV_100_FULL] | adv_i[ADV_10_FULL];

    status_o  = link_i ? STATUS_LINK_UP : 16'h0000;
    partner_o = PARTNER_FIXED | (adv_i & ADV_MODE_MASK);

    diag_o = 16'h0000;
    if (link_i) begin
      diag_o[DIAG_SPEED_BIT]  = speed_100;
      diag_o[DIAG_DUPLEX_BIT] = full_dup;
    end
    duplex_o = diag_o[DIAG_DUPLEX_BIT];
  end

endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
  import phy_mgmt_pkg::*;
#(
  parameter  int NUM_REGS = 32,
  parameter  int DATA_W   = MGMT_DATA_W,
  localparam int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]               sel_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]               status_i,
  input  logic [DATA_W-1:0]               partner_i,
  input  logic [DATA_W-1:0]               diag_i,
  output logic [DATA_W-1:0]               rd_o
);

  always_comb begin
    if (sel_i == ADDR_W'(IDX_STATUS)) begin
      rd_o = status_i;
    end else if (sel_i == ADDR_W'(IDX_PARTNER)) begin
      rd_o = partner_i;
    end else if (sel_i == ADDR_W'(IDX_DIAG)) begin
      rd_o = diag_i;
    end else begin
      rd_o = regs_i[sel_i];
    end
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter  int NUM_REGS    = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(NUM_REGS),
  localparam int DATA_W      = MGMT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up_i,
  input  logic [ADDR_W-1:0] reg_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_duplex_o
);

  logic                             rst_sync_n;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs;
  logic                             link_q;
  logic [DATA_W-1:0]                status_w;
  logic [DATA_W-1:0]                partner_w;
  logic [DATA_W-1:0]                diag_w;

  phy_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  phy_reg_store #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en_i (wr_en_i),
    .sel_i   (reg_sel_i),
    .wdata_i (wr_data_i),
    .link_i  (link_up_i),
    .regs_o  (regs),
    .link_o  (link_q)
  );

  phy_status_synth u_synth (
    .link_i    (link_q),
    .adv_i     (regs[IDX_ADV]),
    .status_o  (status_w),
    .partner_o (partner_w),
    .diag_o    (diag_w),
    .duplex_o  (full_duplex_o)
  );

  phy_read_mux #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_rd_mux (
    .sel_i     (reg_sel_i),
    .regs_i    (regs),
    .status_i  (status_w),
    .partner_i (partner_w),
    .diag_i    (diag_w),
    .rd_o      (rd_data_o)
  );

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        link_q,
  input logic        link_up_i,
  input logic [4:0]  reg_sel_i,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        full_duplex_o
);

  logic plain_sel;
  assign plain_sel = (reg_sel_i != 5'd1) && (reg_sel_i != 5'd5) && (reg_sel_i != 5'd18);

  // R2: a plain register reads back the word written one edge earlier
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && plain_sel) |=>
      ((reg_sel_i != $past(reg_sel_i)) || (rd_data_o == $past(wr_data_i))));

  // R3
  p_status_up_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel_i == 5'd1 && link_q) |-> (rd_data_o == 16'h782C));

  // R4
  p_status_down_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel_i == 5'd1 && !link_q) |-> (rd_data_o == 16'h0000));

  // R5: fixed bits of the partner word
  p_partner_fixed_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel_i == 5'd5) |->
      (rd_data_o[15:14] == 2'b01 && rd_data_o[13:9] == 5'd0 &&
       rd_data_o[4:0] == 5'b00001));

  // R5: mode bits follow a fresh advertisement write
  p_partner_modes_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && reg_sel_i == 5'd4) |=>
      ((reg_sel_i != 5'd5) || (rd_data_o[8:5] == $past(wr_data_i[8:5]))));

  // R6
  p_diag_unused_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel_i == 5'd18) |-> (rd_data_o[15:12] == 4'd0 && rd_data_o[9:0] == 10'd0));

  // R7
  p_duplex_pin_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_sel_i == 5'd18) |-> (rd_data_o[11] == full_duplex_o));

  // R8
  p_down_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !link_q |-> !full_duplex_o);

  // R10
  p_link_sample_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> (link_q == $past(link_up_i)));

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .link_q        (link_q),
  .link_up_i     (link_up_i),
  .reg_sel_i     (reg_sel_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_data_o     (rd_data_o),
  .full_duplex_o (full_duplex_o)
);

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 15;

  // {write sel, write data, link, read sel, expected read, expected duplex}
  localparam logic [43:0] VEC [N_VEC] = '{
    {5'd4,  16'h01E1, 1'b1, 5'd5,  16'h41E1, 1'b1},  // R5
    {5'd4,  16'h0021, 1'b1, 5'd18, 16'h0000, 1'b0},  // R6 R7 10 half
    {5'd4,  16'h0041, 1'b1, 5'd18, 16'h0800, 1'b1},  // R7 10 full
    {5'd4,  16'h0081, 1'b1, 5'd18, 16'h0400, 1'b0},  // R6 100 half
    {5'd4,  16'h0101, 1'b1, 5'd18, 16'h0C00, 1'b1},  // R6 R7 100 full
    {5'd4,  16'h0101, 1'b0, 5'd18, 16'h0000, 1'b0},  // R8
    {5'd4,  16'h0101, 1'b0, 5'd1,  16'h0000, 1'b0},  // R4
    {5'd4,  16'h0101, 1'b0, 5'd5,  16'h4101, 1'b0},  // R5 link down
    {5'd9,  16'hA5C3, 1'b1, 5'd9,  16'hA5C3, 1'b1},  // R2
    {5'd1,  16'hFFFF, 1'b1, 5'd1,  16'h782C, 1'b1},  // R9 R3
    {5'd18, 16'h0000, 1'b1, 5'd18, 16'h0C00, 1'b1},  // R9
    {5'd5,  16'h0000, 1'b1, 5'd5,  16'h4101, 1'b1},  // R9
    {5'd4,  16'hFE1E, 1'b1, 5'd5,  16'h4001, 1'b0},  // R5 no modes
    {5'd31, 16'h1234, 1'b1, 5'd31, 16'h1234, 1'b0},  // R2 top entry
    {5'd4,  16'h0061, 1'b1, 5'd18, 16'h0800, 1'b1}   // R7 both 10 modes
  };

  logic        clk;
  logic        rst_n;
  logic        link_up_i;
  logic [4:0]  reg_sel_i;
  logic        wr_en_i;
  logic [15:0] wr_data_i;
  logic [15:0] rd_data_o;
  logic        full_duplex_o;

  int n_checks;
  int n_errors;

  phy_mgmt_regs dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_up_i     (link_up_i),
    .reg_sel_i     (reg_sel_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .rd_data_o     (rd_data_o),
    .full_duplex_o (full_duplex_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_now(input logic [4:0] sel, input string req, input logic [15:0] exp);
    reg_sel_i = sel;
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic write_reg(input logic [4:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_sel_i = sel;
    wr_data_i = data;
    wr_en_i   = 1'b1;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  initial begin
    n_checks  = 0;
    n_errors  = 0;
    rst_n     = 1'b0;
    link_up_i = 1'b0;
    reg_sel_i = '0;
    wr_en_i   = 1'b0;
    wr_data_i = '0;

    // reset values readable while reset is held
    #(3*CLK_PERIOD + 2);
    read_now(5'd0, "R1", 16'h3100);
    read_now(5'd2, "R1", 16'h0300);
    read_now(5'd3, "R1", 16'hE400);
    read_now(5'd4, "R1", 16'h01E1);
    read_now(5'd7, "R1", 16'h0000);
    read_now(5'd1, "R10 link up in reset", 16'h782C);
    check("R7 duplex pin in reset", {15'd0, full_duplex_o}, 16'h0001);

    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_now(5'd1, "R10 link sampled low", 16'h0000);
    check("R8 duplex pin link down", {15'd0, full_duplex_o}, 16'h0000);
    @(negedge clk);
    link_up_i = 1'b1;
    @(negedge clk);
    read_now(5'd1, "R3", 16'h782C);

    // vector walk
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      link_up_i = VEC[i][22];
      reg_sel_i = VEC[i][43:39];
      wr_data_i = VEC[i][38:23];
      wr_en_i   = 1'b1;
      @(negedge clk);
      wr_en_i   = 1'b0;
      read_now(VEC[i][21:17], $sformatf("vector %0d read", i), VEC[i][16:1]);
      check($sformatf("R7 vector %0d duplex pin", i), {15'd0, full_duplex_o}, {15'd0, VEC[i][0]});
    end

    // R2: neighbouring writes leave each other alone
    write_reg(5'd10, 16'h1111);
    write_reg(5'd11, 16'h2222);
    read_now(5'd10, "R2 neighbour kept", 16'h1111);
    read_now(5'd11, "R2 second word", 16'h2222);
    read_now(5'd4, "R2 adv readback", 16'h0061);

    // R9 with link down
    link_up_i = 1'b0;
    write_reg(5'd1, 16'h782C);
    read_now(5'd1, "R9 status write ignored", 16'h0000);
    write_reg(5'd18, 16'hFFFF);
    read_now(5'd18, "R9 diag write ignored", 16'h0000);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule